// File: doc/BRIEF.md
# Bit-Masked Write Merge for a Dual-Bank Graphics Memory

This block builds the word that a memory array stores during one beat of a write burst. Each beat brings a data word, four byte-lane mask inputs and the word already held at the addressed column. The block merges the incoming data into the stored word. Bits that are masked keep their stored value. Bits that are not masked take the new data.

Two masks act together. The byte-lane inputs act on whole bytes. A 32-bit bit-mask register acts on single bits, but only in a bank whose open row was activated with the bit-masking qualifier. Each bank keeps a flag that records how its row was opened. An activate sets or clears the flag, and a precharge clears it. The bit-mask register is loaded through a plain load port.

The merged word and a cell write strobe come out registered, one clock after the write beat. A beat on which every byte lane is masked raises no write strobe. A cycle with no write beat, such as a slot past the end of a burst, also raises no write strobe.

Top module: `bitmask_write_merge`

## Requirements
- R1: After reset, `cellWe` is 0, `mergedWord` is 0, every bank flag is clear, and the bit-mask register holds all ones, so no bit is blocked.
- R2: The outputs appear one clock after the write beat. A cycle with `wrValid` low gives `cellWe` = 0 and `mergedWord` = 0 on the following clock.
- R3: When `wrDqm[i]` is 1, bits 8i+7..8i of `mergedWord` equal the same bits of `oldWord`. When it is 0, those bits are open to the new data.
- R4: A write to a bank whose flag is clear ignores the bit-mask register. Only the byte lanes decide which bits are written.
- R5: A write to a bank whose flag is set also blocks every bit whose bit-mask register bit is 0. The result is `(wrData & en) | (oldWord & ~en)`, where `en` is the AND of the open byte lanes and the bit-mask register.
- R6: Each bank has its own flag. An activate of that bank sets the flag to `actMaskedWe`. A precharge of that bank, or `preAll`, clears it. Other banks keep their flags.
- R7: When all four `wrDqm` bits are 1, `cellWe` is 0 on the following clock and `mergedWord` equals `oldWord`.
- R8: A `maskLoad` takes effect only for write beats in later cycles. A write beat in the same cycle uses the previous mask.
- R9: A write beat uses the bank flag as it stood before that cycle's activate or precharge. If a precharge and an activate name the same bank in one cycle, the precharge wins and the flag ends clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| actValid | input | 1 | Row activate event |
| actBank | input | 1 | Bank of the activate |
| actMaskedWe | input | 1 | Activate carries the bit-masking qualifier |
| preValid | input | 1 | Precharge of one bank |
| preBank | input | 1 | Bank of the precharge |
| preAll | input | 1 | Precharge of all banks |
| maskLoad | input | 1 | Load the bit-mask register |
| maskData | input | 32 | New bit-mask value (1 = bit may be written) |
| wrValid | input | 1 | Write beat strobe |
| wrBank | input | 1 | Bank of the write beat |
| wrData | input | 32 | Incoming data word |
| wrDqm | input | 4 | Byte-lane masks, 1 = lane blocked |
| oldWord | input | 32 | Word stored at the addressed column |
| cellWe | output | 1 | Registered cell write strobe |
| mergedWord | output | 32 | Registered merged write word |

## Verification
The assertions assume that every bank index on `actBank`, `preBank` and `wrBank` is below the bank count. They also assume that `oldWord` and `wrData` are stable, defined values in any cycle where `wrValid` is high. The stimulus drives only banks 0 and 1. It drives every input to a defined value at each falling edge, and returns the inputs to an idle state after each beat. The corner cases that pair events in one cycle are stimulus the assertions are built to tolerate: a mask load with a write, an activate with a write to the same bank, and an activate with a precharge of one bank. Each of these cases is checked against the stated precedence.

// File: rtl/bwm_pkg.sv
package bwm_pkg;
  parameter int DEF_DATA_W    = 32;
  parameter int DEF_LANE_W    = 8;
  parameter int DEF_NUM_BANKS = 2;

  // strobes passed from the bank control to the merge datapath
  typedef struct packed {
    logic latch;       // a write beat is present this cycle
    logic cellGo;      // at least one lane open: raise the cell strobe
    logic useBitMask;  // addressed bank was opened with bit masking
  } wrStrobe_t;
endpackage

// File: rtl/bwm_bank_ctrl.sv
module bwm_bank_ctrl
  import bwm_pkg::*;
#(
  parameter int NUM_BANKS = DEF_NUM_BANKS,
  parameter int NUM_LANES = DEF_DATA_W / DEF_LANE_W,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 actValid,
  input  logic [BANK_W-1:0]    actBank,
  input  logic                 actMaskedWe,
  input  logic                 preValid,
  input  logic [BANK_W-1:0]    preBank,
  input  logic                 preAll,
  input  logic                 wrValid,
  input  logic [BANK_W-1:0]    wrBank,
  input  logic [NUM_LANES-1:0] wrDqm,
  output wrStrobe_t            strb
);

  logic [NUM_BANKS-1:0] wpbFlag;

  // one mode flag per bank; precharge has priority over activate
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic preHit, actHit;
    assign preHit = preAll || (preValid && (preBank == BANK_W'(b)));
    assign actHit = actValid && (actBank == BANK_W'(b));

    always_ff @(posedge clk) begin
      if (!rstN)       wpbFlag[b] <= 1'b0;
      else if (preHit) wpbFlag[b] <= 1'b0;
      else if (actHit) wpbFlag[b] <= actMaskedWe;
    end
  end

  always_comb begin
    strb.latch      = wrValid;
    strb.cellGo     = wrValid && !(&wrDqm);
    strb.useBitMask = wpbFlag[wrBank];
  end

  // R6 / R9: a precharged bank ends with its flag clear
  p_pre_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    preValid |=> !wpbFlag[$past(preBank)]);

  // R6: precharge-all clears every flag
  p_pre_all_r6: assert property (@(posedge clk) disable iff (!rstN)
    preAll |=> (wpbFlag == '0));

  // R6: an uncontested masked activate sets the flag
  p_act_sets_r6: assert property (@(posedge clk) disable iff (!rstN)
    (actValid && actMaskedWe && !preAll && !(preValid && preBank == actBank))
      |=> wpbFlag[$past(actBank)]);

  // R6: a bank without any event keeps its flag
  p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!actValid && !preValid && !preAll) |=> $stable(wpbFlag));

endmodule

// File: rtl/bwm_merge_dp.sv
module bwm_merge_dp
  import bwm_pkg::*;
#(
  parameter int DATA_W    = DEF_DATA_W,
  parameter int LANE_W    = DEF_LANE_W,
  localparam int NUM_LANES = DATA_W / LANE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  wrStrobe_t            strb,
  input  logic [NUM_LANES-1:0] wrDqm,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [DATA_W-1:0]    oldWord,
  input  logic                 maskLoad,
  input  logic [DATA_W-1:0]    maskData,
  output logic                 cellWe,
  output logic [DATA_W-1:0]    mergedWord
);

  logic [DATA_W-1:0] maskReg;
  logic [DATA_W-1:0] laneEn;
  logic [DATA_W-1:0] bitEn;
  logic [DATA_W-1:0] mergeNext;

  // bit-mask register: all ones after reset blocks nothing
  always_ff @(posedge clk) begin
    if (!rstN)         maskReg <= '1;
    else if (maskLoad) maskReg <= maskData;
  end

  // widen each lane mask bit to its byte
  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    assign laneEn[l*LANE_W +: LANE_W] = {LANE_W{~wrDqm[l]}};
  end

  always_comb begin
    bitEn     = laneEn & (strb.useBitMask ? maskReg : '1);
    mergeNext = (wrData & bitEn) | (oldWord & ~bitEn);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cellWe     <= 1'b0;
      mergedWord <= '0;
    end else begin
      cellWe     <= strb.cellGo;
      mergedWord <= strb.latch ? mergeNext : '0;
    end
  end

  // R2: no beat, nothing written
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latch |=> (!cellWe && mergedWord == '0));

  // R7: all lanes blocked drops the strobe and returns the old word
  p_all_lanes_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.latch && (&wrDqm)) |=> (!cellWe && mergedWord == $past(oldWord)));

  // R3: a blocked lane keeps its stored byte
  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane_chk
    p_lane_keep_r3: assert property (@(posedge clk) disable iff (!rstN)
      (strb.latch && wrDqm[l]) |=>
        (mergedWord[l*LANE_W +: LANE_W] == $past(oldWord[l*LANE_W +: LANE_W])));
  end

  // R4: normal bank with all lanes open writes the whole new word
  p_mask_ignored_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.latch && !strb.useBitMask && wrDqm == '0) |=> (mergedWord == $past(wrData)));

  // R5: masked bank keeps every bit whose mask bit is 0
  p_bit_keep_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.latch && strb.useBitMask) |=>
      ((mergedWord & ~$past(maskReg)) == ($past(oldWord) & ~$past(maskReg))));

endmodule

// File: rtl/bitmask_write_merge.sv
module bitmask_write_merge
  import bwm_pkg::*;
#(
  parameter int DATA_W    = DEF_DATA_W,
  parameter int LANE_W    = DEF_LANE_W,
  parameter int NUM_BANKS = DEF_NUM_BANKS,
  localparam int NUM_LANES = DATA_W / LANE_W,
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 actValid,
  input  logic [BANK_W-1:0]    actBank,
  input  logic                 actMaskedWe,
  input  logic                 preValid,
  input  logic [BANK_W-1:0]    preBank,
  input  logic                 preAll,
  input  logic                 maskLoad,
  input  logic [DATA_W-1:0]    maskData,
  input  logic                 wrValid,
  input  logic [BANK_W-1:0]    wrBank,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [NUM_LANES-1:0] wrDqm,
  input  logic [DATA_W-1:0]    oldWord,
  output logic                 cellWe,
  output logic [DATA_W-1:0]    mergedWord
);

  wrStrobe_t strb;

  bwm_bank_ctrl #(
    .NUM_BANKS (NUM_BANKS),
    .NUM_LANES (NUM_LANES)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .actValid    (actValid),
    .actBank     (actBank),
    .actMaskedWe (actMaskedWe),
    .preValid    (preValid),
    .preBank     (preBank),
    .preAll      (preAll),
    .wrValid     (wrValid),
    .wrBank      (wrBank),
    .wrDqm       (wrDqm),
    .strb        (strb)
  );

  bwm_merge_dp #(
    .DATA_W (DATA_W),
    .LANE_W (LANE_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrDqm      (wrDqm),
    .wrData     (wrData),
    .oldWord    (oldWord),
    .maskLoad   (maskLoad),
    .maskData   (maskData),
    .cellWe     (cellWe),
    .mergedWord (mergedWord)
  );

endmodule

// File: tb/bitmask_write_merge_bench.sv
module bitmask_write_merge_bench;

  localparam int DATA_W = 32;
  localparam int LANES  = 4;
  localparam logic [31:0] MASK = 32'h0F0F_00FF;

  logic        clk = 1'b0;
  logic        rstN;
  logic        actValid, actMaskedWe, preValid, preAll, maskLoad, wrValid;
  logic [0:0]  actBank, preBank, wrBank;
  logic [31:0] maskData, wrData, oldWord;
  logic [3:0]  wrDqm;
  logic        cellWe;
  logic [31:0] mergedWord;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  bitmask_write_merge u_bitmask_write_merge (
    .clk(clk), .rstN(rstN),
    .actValid(actValid), .actBank(actBank), .actMaskedWe(actMaskedWe),
    .preValid(preValid), .preBank(preBank), .preAll(preAll),
    .maskLoad(maskLoad), .maskData(maskData),
    .wrValid(wrValid), .wrBank(wrBank), .wrData(wrData),
    .wrDqm(wrDqm), .oldWord(oldWord),
    .cellWe(cellWe), .mergedWord(mergedWord)
  );

  typedef struct packed {
    logic [0:0]  bank;
    logic [3:0]  dqm;
    logic [31:0] data;
    logic [31:0] old;
  } vec_t;

  // bank 0 opened with bit masking, bank 1 opened normally
  localparam vec_t VECS [8] = '{
    '{1'b1, 4'h0, 32'hA5A5_5A5A, 32'h1234_5678},   // R4 all lanes open
    '{1'b1, 4'h5, 32'hFFFF_FFFF, 32'h0000_0000},   // R3 lanes 0,2 blocked
    '{1'b1, 4'hA, 32'hDEAD_BEEF, 32'hCAFE_F00D},   // R3 lanes 1,3 blocked
    '{1'b1, 4'hF, 32'h1111_1111, 32'h2222_2222},   // R7 all blocked
    '{1'b0, 4'h0, 32'hFFFF_FFFF, 32'h0000_0000},   // R5 mask only
    '{1'b0, 4'h3, 32'hFFFF_FFFF, 32'h0000_0000},   // R5 mask and lanes
    '{1'b0, 4'h8, 32'h3C3C_C3C3, 32'h9999_6666},   // R5
    '{1'b0, 4'hF, 32'hFFFF_FFFF, 32'h5555_AAAA}    // R7 masked bank
  };

  function automatic logic [31:0] expMerge(input logic [31:0] d, input logic [31:0] o,
                                           input logic [3:0] q, input logic useM,
                                           input logic [31:0] m);
    logic [31:0] en;
    for (int l = 0; l < LANES; l++) en[l*8 +: 8] = {8{~q[l]}};
    if (useM) en = en & m;
    return (d & en) | (o & ~en);
  endfunction

  task automatic idle();
    actValid = 0; actBank = 0; actMaskedWe = 0;
    preValid = 0; preBank = 0; preAll = 0;
    maskLoad = 0; maskData = 0;
    wrValid = 0; wrBank = 0; wrData = 0; wrDqm = 0; oldWord = 0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic setWrite(input logic [0:0] b, input logic [3:0] q,
                          input logic [31:0] d, input logic [31:0] o);
    wrValid = 1; wrBank = b; wrDqm = q; wrData = d; oldWord = o;
  endtask

  task automatic check(input string req, input logic expWe, input logic [31:0] expWord);
    total++;
    if (cellWe !== expWe || mergedWord !== expWord) begin
      bad++;
      $display("FAIL %s: cellWe=%b word=%h expected cellWe=%b word=%h",
               req, cellWe, mergedWord, expWe, expWord);
    end
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    idle();
    rstN = 0;
    tick(); tick();
    rstN = 1;
    tick();
    check("R1 reset outputs", 1'b0, 32'h0);

    // R1: bank 0 masked activate; reset mask of all ones blocks nothing
    actValid = 1; actBank = 0; actMaskedWe = 1;
    tick(); idle();
    setWrite(0, 4'h0, 32'hFFFF_FFFF, 32'h0);
    tick(); idle();
    check("R1 mask reset all ones", 1'b1, 32'hFFFF_FFFF);

    // R8: load in same cycle as write uses the old mask
    maskLoad = 1; maskData = MASK;
    setWrite(0, 4'h0, 32'hFFFF_FFFF, 32'h0);
    tick(); idle();
    check("R8 same-cycle load", 1'b1, 32'hFFFF_FFFF);
    setWrite(0, 4'h0, 32'hFFFF_FFFF, 32'h0);
    tick(); idle();
    check("R8 load visible next", 1'b1, MASK);

    // bank 1 normal activate
    actValid = 1; actBank = 1; actMaskedWe = 0;
    tick(); idle();

    foreach (VECS[i]) begin
      setWrite(VECS[i].bank, VECS[i].dqm, VECS[i].data, VECS[i].old);
      tick(); idle();
      check($sformatf("R3/R4/R5/R7 vector %0d", i), !(&VECS[i].dqm),
            expMerge(VECS[i].data, VECS[i].old, VECS[i].dqm, VECS[i].bank == 0, MASK));
    end

    // R2: no beat gives quiet outputs
    tick();
    check("R2 idle cycle", 1'b0, 32'h0);

    // R9: masked activate of bank 1 with a same-cycle write uses the old flag
    actValid = 1; actBank = 1; actMaskedWe = 1;
    setWrite(1, 4'h0, 32'hFFFF_FFFF, 32'h0);
    tick(); idle();
    check("R9 write sees prior flag", 1'b1, 32'hFFFF_FFFF);
    setWrite(1, 4'h0, 32'hFFFF_FFFF, 32'h0);
    tick(); idle();
    check("R6 bank1 now masked", 1'b1, MASK);

    // R6: precharge bank 0 only
    preValid = 1; preBank = 0;
    tick(); idle();
    setWrite(0, 4'h0, 32'hFFFF_FFFF, 32'h0);
    tick(); idle();
    check("R6 precharged bank unmasked", 1'b1, 32'hFFFF_FFFF);
    setWrite(1, 4'h0, 32'hFFFF_FFFF, 32'h0);
    tick(); idle();
    check("R6 other bank keeps flag", 1'b1, MASK);

    // R6: precharge all
    preAll = 1;
    tick(); idle();
    setWrite(1, 4'h0, 32'hFFFF_FFFF, 32'h0);
    tick(); idle();
    check("R6 precharge all clears", 1'b1, 32'hFFFF_FFFF);

    // R9: activate and precharge of bank 0 together, precharge wins
    actValid = 1; actBank = 0; actMaskedWe = 1;
    preValid = 1; preBank = 0;
    tick(); idle();
    setWrite(0, 4'h0, 32'hFFFF_FFFF, 32'h0);
    tick(); idle();
    check("R9 precharge wins", 1'b1, 32'hFFFF_FFFF);

    // R6: normal activate of a masked bank clears its flag
    actValid = 1; actBank = 1; actMaskedWe = 1;
    tick(); idle();
    actValid = 1; actBank = 1; actMaskedWe = 0;
    tick(); idle();
    setWrite(1, 4'h0, 32'hFFFF_FFFF, 32'h0);
    tick(); idle();
    check("R6 normal activate clears", 1'b1, 32'hFFFF_FFFF);

    // R2: beat past burst end is not written
    tick();
    check("R2 past burst end", 1'b0, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule